// File: doc/BRIEF.md
# GPIO Port with Break-Before-Make Direction Switching

This block is one general-purpose I/O port of configurable width (eight bits by default). Software sets three things for each bit: whether it is an output, the value it drives, or whether its pull-up is on when it is an input. The block turns these into three signals per bit for the pad: a drive value, an output enable and a pull-up enable. Pad input levels pass through a synchronizer and can be read back. Writing ones to the pin-read address inverts the matching output-value bits in one write, whatever their direction.

A port-wide break-before-make option keeps a bit undriven for one clock cycle when it turns from input to output. This avoids contention with an external driver that has not yet let go of the line. Turning a bit from output to input always removes its drive straight away. A chip-level pull-up disable input turns off every pull-up in the port.

Per bit, the pair {direction, value} is decoded as follows:

| {direction, value} | Pad state |
|---|---|
| 00 | floating input |
| 01 | input with pull-up |
| 10 | drives low |
| 11 | drives high |

Register writes are made with a single strobe. Reads are combinational.

Top module: `gpio_bbm_port`

## Requirements
- R1: A write to address 2 inverts each value bit (`port_q`) whose write-data bit is 1 and leaves the value bits with write-data 0 unchanged, for any direction setting. The result is visible from the next cycle.
- R2: For each bit, {direction, value} = 10 gives `pad_oe`=1 and `pad_out`=0, and 11 gives `pad_oe`=1 and `pad_out`=1. When the direction bit is 0, `pad_oe`=0.
- R3: With break-before-make enabled (control bit 0 = 1), a direction bit written from 0 to 1 keeps `pad_oe` low for exactly the first cycle after the write. From the second cycle the bit drives its value.
- R4: A direction bit written from 1 to 0 drops `pad_oe` in the first cycle after the write, whether break-before-make is on or off.
- R5: With break-before-make disabled, `pad_oe` equals the written direction value in the first cycle after a write to address 0.
- R6: While `pull_dis` is 1, `pad_pu` is 0 for every bit, including bits in state 01.
- R7: `pad_pu` is 1 only for a bit in state 01 while `pull_dis` is 0. A bit never has `pad_pu` and `pad_oe` both at 1, and this includes the one-cycle break-before-make gap.
- R8: A read of address 2 returns `pad_in` delayed through two flops: after a clock edge, it shows the value sampled at the edge before. It never returns the value register.
- R9: Reset clears direction, value, break-before-make enable, hold state and synchronizer. While reset is held and after it, every pad is undriven with no pull-up, and every read returns 0.
- R10: Reads are combinational. Address 0 returns direction, address 1 returns value, address 3 returns the break-before-make enable in bit 0, and every other bit of address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 direction, 1 value, 2 pin/toggle, 3 control |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data for `addr` |
| pad_in | input | WIDTH | Asynchronous pad input levels |
| pull_dis | input | 1 | Global pull-up disable |
| pad_out | output | WIDTH | Pad drive value |
| pad_oe | output | WIDTH | Pad output enable |
| pad_pu | output | WIDTH | Pad pull-up enable |

## Verification
The bench builds the block with its default parameters: eight bits and a two-flop synchronizer. This keeps every pad bit within reach of random byte patterns, and it fixes the pin-read delay at two edges so a short history queue can predict it. Random phases cover both break-before-make settings and both states of the pull-up disable. Direction writes are spaced at least two cycles apart. Directed phases exercise toggling with mixed directions, the one-cycle gap in both directions of switching, and reads during reset.

// File: rtl/gpio_bbm_port.sv
module gpio_bbm_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pad_in,
  input  logic             pull_dis,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);

  localparam logic [1:0] A_DIR  = 2'd0;
  localparam logic [1:0] A_VAL  = 2'd1;
  localparam logic [1:0] A_PIN  = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;

  logic [WIDTH-1:0] dir_q, port_q, hold_q;
  logic             bbm_en;
  logic [WIDTH-1:0] sync_q [SYNC_STAGES];

  wire wr_dir  = wr_en && addr == A_DIR;
  wire wr_val  = wr_en && addr == A_VAL;
  wire wr_pin  = wr_en && addr == A_PIN;
  wire wr_ctrl = wr_en && addr == A_CTRL;

  wire [WIDTH-1:0] rising_dir = wdata & ~dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      port_q <= '0;
      hold_q <= '0;
      bbm_en <= 1'b0;
    end else begin
      hold_q <= (wr_dir && bbm_en) ? rising_dir : '0;
      if (wr_dir)  dir_q  <= wdata;
      if (wr_val)  port_q <= wdata;
      if (wr_pin)  port_q <= port_q ^ wdata;
      if (wr_ctrl) bbm_en <= wdata[0];
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sync_q[s] <= '0;
        else if (s == 0) sync_q[s] <= pad_in;
        else            sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  assign pad_oe  = dir_q & ~hold_q;
  assign pad_out = port_q & pad_oe;
  assign pad_pu  = ~dir_q & port_q & ~hold_q & {WIDTH{~pull_dis}};

  always_comb begin
    case (addr)
      A_DIR:   rdata = dir_q;
      A_VAL:   rdata = port_q;
      A_PIN:   rdata = sync_q[SYNC_STAGES-1];
      default: rdata = {{(WIDTH-1){1'b0}}, bbm_en};
    endcase
  end

  p_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pin |=> port_q == ($past(port_q) ^ $past(wdata)));

  p_bbm_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir && bbm_en) |=> (pad_oe & ($past(wdata) & ~$past(dir_q))) == '0);

  p_gap_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|hold_q) |=> (pad_oe & $past(hold_q)) == ($past(hold_q) & dir_q));

  p_off_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pad_oe & ~$past(wdata)) == '0);

  p_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir && !bbm_en) |=> pad_oe == $past(wdata));

  p_pull_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pull_dis |-> pad_pu == '0);

  p_pu_oe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

endmodule

// File: tb/gpio_bbm_port_test.sv
module gpio_bbm_port_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [7:0] pad_in = 0;
  logic       pull_dis = 0;
  logic [7:0] pad_out, pad_oe, pad_pu;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  gpio_bbm_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pull_dis(pull_dis),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  always #5 clk = ~clk;

  // reference model
  logic [7:0] m_dir = 0, m_val = 0, m_hold = 0;
  logic       m_bbm = 0;
  logic [7:0] m_hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 0; m_val = 0; m_hold = 0; m_bbm = 0;
      m_hist.delete();
    end else begin
      logic [7:0] nh;
      nh = 0;
      if (wr_en) begin
        case (addr)
          2'd0: begin
            if (m_bbm) nh = wdata & ~m_dir;
            m_dir = wdata;
          end
          2'd1: m_val = wdata;
          2'd2: m_val = m_val ^ wdata;
          default: m_bbm = wdata[0];
        endcase
      end
      m_hold = nh;
      m_hist.push_back(pad_in);
      if (m_hist.size() > 2) void'(m_hist.pop_front());
    end
  end

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    logic [7:0] e_oe, e_out, e_pu, e_rd;
    cycles++;
    e_oe  = m_dir & ~m_hold;
    e_out = m_val & e_oe;
    e_pu  = ~m_dir & m_val & ~m_hold & {8{~pull_dis}};
    case (addr)
      2'd0: e_rd = m_dir;
      2'd1: e_rd = m_val;
      2'd2: e_rd = (m_hist.size() == 2) ? m_hist[0] : 8'h00;
      default: e_rd = {7'b0, m_bbm};
    endcase
    check(pad_oe == e_oe, "R2/R3/R4/R5 pad_oe", pad_oe, e_oe);
    check(pad_out == e_out, "R2 pad_out", pad_out, e_out);
    check(pad_pu == e_pu, "R6/R7 pad_pu", pad_pu, e_pu);
    check(rdata == e_rd, "R8/R10 rdata", rdata, e_rd);
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk); #1;
      wr_en = 0;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic look(input logic [1:0] a);
    @(negedge clk); #1;
    addr = a;
  endtask

  initial begin
    // R9: reset state, reads during reset
    for (int a = 0; a < 4; a++) begin
      look(a[1:0]);
      pad_in = 8'hFF;
      @(negedge clk);
      check(rdata == 0 && pad_oe == 0 && pad_pu == 0, "R9 reset", rdata | pad_oe | pad_pu, 8'h00);
    end
    @(negedge clk); #1;
    rst_n = 1;
    pad_in = 8'h00;

    // R2/R5: direct drive, BBM off
    wr(2'd1, 8'h5A);
    wr(2'd0, 8'hF0);
    check(pad_oe == 8'hF0, "R5 immediate drive", pad_oe, 8'hF0);
    check(pad_out == 8'h50, "R2 drive value", pad_out, 8'h50);
    check(pad_pu == 8'h0A, "R7 pull-up on 01 bits", pad_pu, 8'h0A);
    idle(1);

    // R1: toggle across both directions
    wr(2'd2, 8'h3C);
    look(2'd1);
    @(negedge clk);
    check(rdata == 8'h66, "R1 toggle", rdata, 8'h66);

    // R6: pull-up disable
    @(negedge clk); #1;
    pull_dis = 1;
    @(negedge clk);
    check(pad_pu == 8'h00, "R6 pull_dis", pad_pu, 8'h00);
    #1 pull_dis = 0;

    // R3: break-before-make gap
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h00);
    idle(1);
    wr(2'd1, 8'hA5);
    wr(2'd0, 8'hFF);
    check(pad_oe == 8'h00, "R3 gap cycle", pad_oe, 8'h00);
    check(pad_pu == 8'h00, "R7 no pull-up in gap", pad_pu, 8'h00);
    @(negedge clk);
    check(pad_oe == 8'hFF, "R3 drive after gap", pad_oe, 8'hFF);
    idle(1);

    // R4: output to input with BBM on
    wr(2'd0, 8'h0F);
    check(pad_oe == 8'h0F, "R4 immediate release", pad_oe, 8'h0F);
    idle(1);

    // R8: PIN read shows synchronized pads, not PORT
    look(2'd2);
    pad_in = 8'hC3;
    @(negedge clk);
    check(rdata != 8'hC3, "R8 one edge not enough", rdata, 8'hC3);
    @(negedge clk);
    check(rdata == 8'hC3, "R8 sync", rdata, 8'hC3);
    look(2'd3);
    @(negedge clk);
    check(rdata == 8'h01, "R10 control read", rdata, 8'h01);

    // random phases
    for (int ph = 0; ph < 4; ph++) begin
      wr(2'd3, {7'b0, ph[0]});
      for (int i = 0; i < 400; i++) begin
        logic [1:0] a;
        a = 2'($urandom_range(0, 3));
        pull_dis = ph[1] ^ ($urandom_range(0, 7) == 0);
        pad_in = 8'($urandom);
        if ($urandom_range(0, 2) == 0) look(a);
        else begin
          if (a == 2'd3 && $urandom_range(0, 3) != 0) a = 2'd2;
          wr(a, 8'($urandom));
          if (a == 2'd0) idle(1);
        end
      end
    end

    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule